// File: doc/BRIEF.md
# Self-Clocked Header-Aligning Serial Receiver

This receiver takes in the result words of a converter whose serial link returns no clock. On a `start` request it sends a burst of shift-clock pulses to the converter, one pulse every three host clock cycles. The converter answers on a single data line with a short header and then the result bits, MSB first. Each bit reaches the host after a board propagation delay that is not known in advance and may be several shift-clock periods long.

The receiver samples the data line at three phases per shift-clock period. It searches for the first '1' of the header and records how many host cycles after the burst start that '1' appeared. From that edge it picks one sample near the middle of every following bit. It checks that the bit after the header '1' is '0', then shifts in the result bits and presents them as a two's complement word with a one-cycle valid strobe. The delay is measured again on every conversion and exported. A change from the previous measurement sets a sticky warning. A missing or malformed header raises a one-cycle sync-error pulse, and that word is discarded. A parameter selects the converter variant that sends one extra leading zero.

Top module: `hdr_align_rx`

## Requirements
- R1: While `rst_n` is low and after its release, `sclk`, `word`, `word_valid`, `sync_err`, `offset` and `offset_warn` are all zero.
- R2: `start` is accepted only when no burst is running and no word is being received. An accepted `start` produces exactly WIDTH+2+EXTRA_ZERO pulses on `sclk` (18 by default). Each pulse is high for one clock cycle out of three. A `start` during a burst or a reception adds no pulse.
- R3: `offset` equals N, where the clock period in which `sdata` is first high is the Nth period after the edge that accepted `start`. With the default converter timing this is 2 + (line delay in cycles) + 3*EXTRA_ZERO.
- R4: After the header '1' is detected, every later bit is sampled once, 4+3k cycles after the detection edge. This places the sample near the middle of each three-cycle bit, whatever the line delay is.
- R5: The WIDTH bits after the header '0' are assembled MSB first into `word`, a two's complement value. `word_valid` pulses for one cycle when `word` is updated, and `word` does not change at any other time.
- R6: If the bit sampled after the header '1' is not '0', `sync_err` pulses for one cycle. No `word_valid` follows and `word` keeps its old value.
- R7: If `sdata` has not been seen high by the time the search count reaches SEARCH_MAX, `sync_err` pulses and the word is discarded. A '1' found at exactly `offset` = SEARCH_MAX is still accepted.
- R8: `offset_warn` is set when a newly measured offset differs from the one measured for the previous conversion. It stays set until reset. It is not set by the first measurement or by an equal one.
- R9: With EXTRA_ZERO = 1 the burst has WIDTH+3 pulses, the measured offset is 3 cycles larger, and the word is decoded correctly.
- R10: `word_valid` and `sync_err` are never high in the same cycle, and each accepted `start` ends in at most one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock, three times the shift-clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one conversion readout |
| sdata | input | 1 | Serial data line from the converter |
| sclk | output | 1 | Shift clock to the converter |
| word | output | WIDTH | Last received result, two's complement |
| word_valid | output | 1 | One-cycle strobe when `word` is updated |
| sync_err | output | 1 | One-cycle pulse on a missing or malformed header |
| offset | output | OFFW | Measured line delay in host cycles |
| offset_warn | output | 1 | Sticky flag: measured delay has changed |

## Verification
A wrong phase counter or detection point makes the receiver sample bits at their edges instead of their middles. At larger delays this shows as a corrupted `word` on the first conversion, within about 55 cycles of `start`. An off-by-one in the search counter shows at once in `offset`, and at the SEARCH_MAX boundary it turns an accepted word into a `sync_err`. A burst counter or busy-gating fault shows as a wrong number of `sclk` pulses in that same burst. A fault in the stored previous offset shows on the next conversion as a wrong `offset_warn`.

// File: rtl/hdr_align_rx.sv
module hdr_align_rx #(
  parameter int WIDTH      = 16,
  parameter int EXTRA_ZERO = 0,
  parameter int SEARCH_MAX = 24,
  localparam int NPULSE = WIDTH + 2 + EXTRA_ZERO,
  localparam int PW     = $clog2(NPULSE + 1),
  localparam int OFFW   = $clog2(SEARCH_MAX + 1),
  localparam int BW     = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             sdata,
  output logic             sclk,
  output logic [WIDTH-1:0] word,
  output logic             word_valid,
  output logic             sync_err,
  output logic [OFFW-1:0]  offset,
  output logic             offset_warn
);

  typedef enum logic [1:0] {S_IDLE, S_SEARCH, S_HDR, S_DATA} st_t;

  st_t             st;
  logic            sd_q;
  logic            gen_on;
  logic [1:0]      sph;
  logic [PW-1:0]   pcnt;
  logic [OFFW-1:0] tcnt;
  logic [1:0]      ph;
  logic [BW-1:0]   bcnt;
  logic [WIDTH-2:0] sh;
  logic            have_prev;

  wire busy   = gen_on || (st != S_IDLE);
  wire accept = start && !busy;
  wire sample = (ph == 2'd2);

  assign sclk = gen_on && (sph == 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_on <= 1'b0;
      sph    <= 2'd0;
      pcnt   <= '0;
    end else if (accept) begin
      gen_on <= 1'b1;
      sph    <= 2'd0;
      pcnt   <= '0;
    end else if (gen_on) begin
      if (sph == 2'd2) begin
        sph  <= 2'd0;
        pcnt <= pcnt + 1'b1;
        if (pcnt == PW'(NPULSE - 1)) gen_on <= 1'b0;
      end else begin
        sph <= sph + 2'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      sd_q        <= 1'b0;
      tcnt        <= '0;
      ph          <= 2'd0;
      bcnt        <= '0;
      sh          <= '0;
      word        <= '0;
      word_valid  <= 1'b0;
      sync_err    <= 1'b0;
      offset      <= '0;
      offset_warn <= 1'b0;
      have_prev   <= 1'b0;
    end else begin
      sd_q       <= sdata;
      word_valid <= 1'b0;
      sync_err   <= 1'b0;
      if (st == S_HDR || st == S_DATA)
        ph <= (ph >= 2'd2) ? 2'd0 : ph + 2'd1;
      case (st)
        S_IDLE: begin
          if (accept) begin
            st   <= S_SEARCH;
            tcnt <= '0;
          end
        end
        S_SEARCH: begin
          if (sd_q) begin
            if (have_prev && (tcnt != offset)) offset_warn <= 1'b1;
            offset    <= tcnt;
            have_prev <= 1'b1;
            ph        <= 2'd3;
            st        <= S_HDR;
          end else if (tcnt == OFFW'(SEARCH_MAX)) begin
            sync_err <= 1'b1;
            st       <= S_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        S_HDR: begin
          if (sample) begin
            if (sd_q) begin
              sync_err <= 1'b1;
              st       <= S_IDLE;
            end else begin
              bcnt <= '0;
              st   <= S_DATA;
            end
          end
        end
        S_DATA: begin
          if (sample) begin
            sh <= {sh[WIDTH-3:0], sd_q};
            if (bcnt == BW'(WIDTH - 1)) begin
              word       <= {sh, sd_q};
              word_valid <= 1'b1;
              st         <= S_IDLE;
            end else begin
              bcnt <= bcnt + 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/hdr_align_rx_chk.sv
module hdr_align_rx_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sclk,
  input logic [W-1:0] word,
  input logic         word_valid,
  input logic         sync_err,
  input logic         offset_warn
);

  a_r2_sclk_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |=> !sclk);

  a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  a_r5_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word) |-> word_valid);

  a_r6_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |=> !sync_err);

  a_r8_warn_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    offset_warn |=> offset_warn);

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_valid && sync_err));

endmodule

bind hdr_align_rx hdr_align_rx_chk #(.W(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .word(word),
  .word_valid(word_valid), .sync_err(sync_err), .offset_warn(offset_warn)
);

// File: tb/tb_hdr_align_rx.sv
`timescale 1ns/1ps

module tb_line_model #(
  parameter int EXTRA = 0
) (
  input  logic        clk,
  input  logic        sclk,
  input  logic        arm,
  input  int          dly,
  input  logic [15:0] w,
  input  logic [1:0]  mode,
  output logic        sdata
);
  logic        prev;
  int          k;
  logic [31:0] dl;
  logic        cur;

  function automatic logic bit_at(input int kk);
    int idx;
    idx = kk - EXTRA;
    if (mode == 2'd2) return 1'b0;
    if (idx < 1) return 1'b0;
    if (idx == 1) return 1'b1;
    if (idx == 2) return (mode == 2'd1);
    if (idx <= 18) return w[18-idx];
    return 1'b0;
  endfunction

  initial begin
    prev = 1'b0; k = 0; dl = '0; sdata = 1'b0; cur = 1'b0;
  end

  always @(negedge clk) begin
    if (arm) begin
      k = 0; prev = 1'b0; dl = '0; sdata = 1'b0;
    end else begin
      if (prev && !sclk) k = k + 1;
      prev  = sclk;
      cur   = bit_at(k);
      dl    = {dl[30:0], cur};
      sdata = dl[dly];
    end
  end
endmodule

module tb_hdr_align_rx;
  localparam int OFFW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start0 = 1'b0, start1 = 1'b0;
  logic arm0 = 1'b0, arm1 = 1'b0;
  int   dly_m = 0;
  logic [15:0] w_m = '0;
  logic [1:0]  mode_m = '0;
  logic sd0, sd1, sclk0, sclk1, v0, v1, e0, e1, warn0, warn1;
  logic [15:0] word0, word1;
  logic [OFFW-1:0] off0, off1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hdr_align_rx dut (
    .clk(clk), .rst_n(rst_n), .start(start0), .sdata(sd0), .sclk(sclk0),
    .word(word0), .word_valid(v0), .sync_err(e0), .offset(off0), .offset_warn(warn0));

  hdr_align_rx #(.EXTRA_ZERO(1)) dut_x (
    .clk(clk), .rst_n(rst_n), .start(start1), .sdata(sd1), .sclk(sclk1),
    .word(word1), .word_valid(v1), .sync_err(e1), .offset(off1), .offset_warn(warn1));

  tb_line_model #(.EXTRA(0)) m0 (.clk(clk), .sclk(sclk0), .arm(arm0), .dly(dly_m),
    .w(w_m), .mode(mode_m), .sdata(sd0));
  tb_line_model #(.EXTRA(1)) m1 (.clk(clk), .sclk(sclk1), .arm(arm1), .dly(dly_m),
    .w(w_m), .mode(mode_m), .sdata(sd1));

  // delay, word
  localparam int NV = 6;
  localparam logic [23:0] VEC [NV] = '{
    {8'd4,  16'h8001}, {8'd4,  16'h7FFF}, {8'd0, 16'h0000},
    {8'd1,  16'hFFFF}, {8'd7,  16'hA5C3}, {8'd13, 16'h1234}};

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run(input bit x, input int d, input logic [15:0] w,
                     input logic [1:0] md, input bit dbl,
                     output int nv, output int ne, output int nr,
                     output logic [15:0] gw);
    logic ps;
    ps = 1'b0; nv = 0; ne = 0; nr = 0; gw = '0;
    @(posedge clk); #1;
    dly_m = d; w_m = w; mode_m = md;
    if (x) arm1 = 1'b1; else arm0 = 1'b1;
    @(posedge clk); #1;
    arm0 = 1'b0; arm1 = 1'b0;
    if (x) start1 = 1'b1; else start0 = 1'b1;
    @(posedge clk); #1;
    start0 = 1'b0; start1 = 1'b0;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (dbl && i == 10) begin if (x) start1 = 1'b1; else start0 = 1'b1; end
      if (i == 11) begin start0 = 1'b0; start1 = 1'b0; end
      if ((x ? sclk1 : sclk0) && !ps) nr++;
      ps = x ? sclk1 : sclk0;
      if (x ? v1 : v0) begin nv++; gw = x ? word1 : word0; end
      if (x ? e1 : e0) ne++;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int nv, ne, nr;
    logic [15:0] gw;
    logic [15:0] last;
    bit exp_warn;
    int prev_off;

    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(sclk0 == 0 && v0 == 0 && e0 == 0, "R1", "strobes in reset", {sclk0, v0, e0}, 0);
    chk(word0 == 0 && off0 == 0 && warn0 == 0, "R1", "state in reset", word0, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(word0 == 0 && off0 == 0 && warn0 == 0 && sclk0 == 0, "R1", "after release",
        word0, 0);

    exp_warn = 1'b0;
    prev_off = -1;
    for (int i = 0; i < NV; i++) begin
      int d;
      d = int'(VEC[i][23:16]);
      run(1'b0, d, VEC[i][15:0], 2'd0, 1'b0, nv, ne, nr, gw);
      chk(nr == 18, "R2", "pulse count", nr, 18);
      chk(nv == 1 && ne == 0, "R10", "single outcome", nv, 1);
      chk(gw == VEC[i][15:0], "R5", "word value (R4 sampling)", gw, VEC[i][15:0]);
      chk(word0 == VEC[i][15:0], "R5", "word held", word0, VEC[i][15:0]);
      chk(int'(off0) == 2 + d, "R3", "offset", off0, 2 + d);
      if (prev_off >= 0 && prev_off != 2 + d) exp_warn = 1'b1;
      prev_off = 2 + d;
      chk(warn0 == exp_warn, "R8", "offset warning", warn0, exp_warn);
    end
    last = word0;

    // R6: malformed header
    run(1'b0, 3, 16'h5555, 2'd1, 1'b0, nv, ne, nr, gw);
    chk(ne == 1, "R6", "bad header error pulse", ne, 1);
    chk(nv == 0, "R6", "bad header no valid", nv, 0);
    chk(word0 == last, "R6", "word kept", word0, last);

    // R7: window boundary
    run(1'b0, 22, 16'h3C5A, 2'd0, 1'b0, nv, ne, nr, gw);
    chk(nv == 1 && ne == 0 && gw == 16'h3C5A, "R7", "found at window edge", gw, 16'h3C5A);
    chk(int'(off0) == 24, "R7", "offset at window edge", off0, 24);
    last = word0;
    run(1'b0, 23, 16'hFFFF, 2'd0, 1'b0, nv, ne, nr, gw);
    chk(ne == 1 && nv == 0, "R7", "just past window", ne, 1);
    chk(word0 == last, "R7", "word kept past window", word0, last);
    run(1'b0, 0, 16'hFFFF, 2'd2, 1'b0, nv, ne, nr, gw);
    chk(ne == 1 && nv == 0, "R7", "silent line", ne, 1);
    chk(word0 == last, "R7", "word kept on silent line", word0, last);

    // R2: start while busy ignored
    run(1'b0, 5, 16'h0F0F, 2'd0, 1'b1, nv, ne, nr, gw);
    chk(nr == 18, "R2", "pulses with extra start", nr, 18);
    chk(nv == 1 && gw == 16'h0F0F, "R2", "word with extra start", gw, 16'h0F0F);

    // R9: extra leading zero variant
    run(1'b1, 0, 16'h8000, 2'd0, 1'b0, nv, ne, nr, gw);
    chk(nr == 19, "R9", "pulse count", nr, 19);
    chk(nv == 1 && ne == 0 && gw == 16'h8000, "R9", "word", gw, 16'h8000);
    chk(int'(off1) == 5, "R9", "offset", off1, 5);
    run(1'b1, 6, 16'h6B2D, 2'd0, 1'b0, nv, ne, nr, gw);
    chk(nv == 1 && gw == 16'h6B2D, "R9", "word delayed", gw, 16'h6B2D);
    chk(int'(off1) == 11, "R9", "offset delayed", off1, 11);
    chk(warn1 == 1'b1, "R8", "warning on variant", warn1, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule